// File: doc/BRIEF.md
# Smart Card Interface Mode Controller

This block is the host-facing control logic that sits between a microcontroller and a smart card socket. It decodes chip select, power-on, a program strobe and two address lines to choose among three modes. In programming mode the host data pins act as register inputs. In active mode the host polls a status line. In transaction mode the host data and reset lines pass through to the card. The configuration it holds covers three settings: which of two card supply levels is used, the divider and mode of the card clock, and the polarity of the card-detect switch.

A configuration write uses a chip-select handshake. Chip select falls while the program strobe is low, and this latches programming mode. While that mode is latched, the card-side lines are frozen and the host lines are isolated. The value on the host I/O and RESET pins is captured when chip select rises, provided the program strobe is still low at that edge. The card detect input is synchronized and corrected for polarity, and any change in it raises an interrupt. Once the host asserts power-on with a card present and the comparator for the selected supply reports good, a sequencer brings up card I/O, then the card clock, then the card reset. Any loss of supply collapses all of these at once.

All inputs are sampled on the system clock. The card clock is derived from that clock by a divider.

Top module: `sc_mode_ctrl`

## Requirements
- R1: After reset the following outputs are all 0: card supply enable, supply select, card clock, card reset, card I/O and its enable, status, interrupt and programming-mode flag. The host-isolation output is 1.
- R2: A chip-select fall with the program strobe low sets the programming-mode flag one clock later. The flag stays set while chip select is low, even after the strobe returns high. It clears on the clock where chip select is seen high.
- R3: On a chip-select rise with the flag set and the program strobe low, the address {a1,a0} picks the write. 00 writes nothing. 01 loads supply select from host I/O. 10 loads clock mode {host I/O, host RESET}. 11 loads detect polarity from host I/O.
- R4: If the program strobe is high at the chip-select rise, the configuration is not changed.
- R5: Card present is the synchronized detect input XOR the polarity bit. In active mode (cs_n=0, pwr_on=0, a1=a0=0, program strobe high, flag clear) status reports card present. Otherwise status reports the comparator for the selected supply.
- R6: A change in card present sets the interrupt. Each chip-select rise clears it. If a set and a clear fall on the same clock, the set wins.
- R7: The card supply enable is power-on AND card present, registered.
- R8: Activation starts only when the supply enable is high and the selected comparator reports good. Supply select 1 uses uv5_ok and supply select 0 uses uv3_ok.
- R9: Activation order: card I/O enable rises first. The clock is started STEP_CYC clocks later. Card reset follows host RESET from 2*STEP_CYC clocks after the I/O enable rises.
- R10: Clock mode 00 holds the card clock low. Modes 01, 10 and 11 produce the system clock divided by 2, 4 and 8.
- R11: When the supply enable or the selected comparator drops, card I/O enable and card reset go low on the next clock and the card clock is low one clock after that.
- R12: In transaction mode the card I/O and card reset follow host I/O and host RESET one clock later, and host isolation is 0. While the programming-mode flag is set, both hold their values and host isolation is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| pwr_on | input | 1 | Host request for card power |
| pgm_n | input | 1 | Program strobe, active low |
| a0 | input | 1 | Address bit 0 |
| a1 | input | 1 | Address bit 1 |
| hio_in | input | 1 | Host I/O line level |
| hrst_in | input | 1 | Host RESET line level |
| card_det | input | 1 | Raw card detect switch, asynchronous |
| uv3_ok | input | 1 | Low-voltage supply above its threshold |
| uv5_ok | input | 1 | High-voltage supply above its threshold |
| card_vcc_en | output | 1 | Card supply converter enable |
| card_vsel | output | 1 | Supply select, 1 = high level |
| card_clk | output | 1 | Card clock |
| card_rst | output | 1 | Card reset |
| card_io | output | 1 | Card I/O level |
| card_io_oe | output | 1 | Card I/O driver enable |
| status | output | 1 | Card present or supply good |
| irq | output | 1 | Card detect change interrupt |
| prog_mode | output | 1 | Programming mode latched |
| host_hiz | output | 1 | Host I/O and RESET isolated from card |

## Verification
The hardest state to reach from the ports is a reconfiguration during a live transaction. To get there, the bench first performs a full activation: a card detect, power-on, a decoy comparator on the wrong supply, and then the correct comparator. Only after that does it run chip-select handshakes that change the clock mode. It counts card clock transitions over a fixed window for each mode, and checks that the card lines freeze while the programming flag is latched. The sequencer order is measured as cycle distances between the first samples at which card I/O enable, card clock and card reset go high.

// File: rtl/scm_pkg.sv
package scm_pkg;
    typedef enum logic [1:0] {
        SEQ_OFF  = 2'd0,
        SEQ_IO   = 2'd1,
        SEQ_CLK  = 2'd2,
        SEQ_LIVE = 2'd3
    } seq_e;

    typedef struct packed {
        logic       vsel;
        logic [1:0] ckmode;
        logic       pol;
    } cfg_t;

    localparam logic [1:0] ADDR_NONE = 2'd0;
    localparam logic [1:0] ADDR_VSEL = 2'd1;
    localparam logic [1:0] ADDR_CLK  = 2'd2;
    localparam logic [1:0] ADDR_POL  = 2'd3;
endpackage

// File: rtl/scm_detsync.sv
module scm_detsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/scm_cfgreg.sv
module scm_cfgreg
    import scm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       pgm_n,
    input  logic [1:0] addr,
    input  logic       hio,
    input  logic       hrst,
    output cfg_t       cfg,
    output logic       prog,
    output logic       cs_rise
);
    typedef struct packed {
        logic cs_prev;
        logic prog;
        cfg_t cfg;
    } st_t;

    st_t  st_d, st_q;
    logic cs_fall;
    logic cap;

    always_comb begin
        st_d    = st_q;
        cs_rise = cs_n & ~st_q.cs_prev;
        cs_fall = ~cs_n & st_q.cs_prev;
        cap     = cs_rise & st_q.prog & ~pgm_n;
        st_d.cs_prev = cs_n;
        if (cs_n)                 st_d.prog = 1'b0;
        else if (cs_fall & ~pgm_n) st_d.prog = 1'b1;
        if (cap) begin
            case (addr)
                ADDR_VSEL: st_d.cfg.vsel   = hio;
                ADDR_CLK:  st_d.cfg.ckmode = {hio, hrst};
                ADDR_POL:  st_d.cfg.pol    = hio;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cs_prev <= 1'b1;
            st_q.prog    <= 1'b0;
            st_q.cfg     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg  = st_q.cfg;
    assign prog = st_q.prog;

    AST_PROG_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !prog); // R2
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_rise || pgm_n) |=> $stable(cfg)); // R4
endmodule

// File: rtl/scm_actseq.sv
module scm_actseq
    import scm_pkg::*;
#(
    parameter int STEP_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output seq_e state
);
    localparam int CW = $clog2(STEP_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(STEP_CYC - 1);

    typedef struct packed {
        seq_e          st;
        logic [CW-1:0] cnt;
    } sq_t;

    sq_t sq_d, sq_q;

    always_comb begin
        sq_d = sq_q;
        if (!go) begin
            sq_d.st  = SEQ_OFF;
            sq_d.cnt = '0;
        end else begin
            case (sq_q.st)
                SEQ_OFF: begin
                    sq_d.st  = SEQ_IO;
                    sq_d.cnt = '0;
                end
                SEQ_IO, SEQ_CLK: begin
                    if (sq_q.cnt == LAST) begin
                        sq_d.st  = (sq_q.st == SEQ_IO) ? SEQ_CLK : SEQ_LIVE;
                        sq_d.cnt = '0;
                    end else begin
                        sq_d.cnt = sq_q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q.st  <= SEQ_OFF;
            sq_q.cnt <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign state = sq_q.st;

    AST_SEQ_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_OFF) |=> (state == SEQ_OFF || state == SEQ_IO)); // R9
    AST_SEQ_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> (state == SEQ_OFF)); // R11
endmodule

// File: rtl/sc_mode_ctrl.sv
module sc_mode_ctrl
    import scm_pkg::*;
#(
    parameter int STEP_CYC    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic pwr_on,
    input  logic pgm_n,
    input  logic a0,
    input  logic a1,
    input  logic hio_in,
    input  logic hrst_in,
    input  logic card_det,
    input  logic uv3_ok,
    input  logic uv5_ok,
    output logic card_vcc_en,
    output logic card_vsel,
    output logic card_clk,
    output logic card_rst,
    output logic card_io,
    output logic card_io_oe,
    output logic status,
    output logic irq,
    output logic prog_mode,
    output logic host_hiz
);
    localparam int NMODES = 4;
    localparam int DIV_W  = NMODES - 1;

    typedef struct packed {
        logic             pres;
        logic             irq;
        logic             vcc_en;
        logic             status;
        logic             io_hold;
        logic             rst_hold;
        logic [DIV_W-1:0] div;
        logic             cclk;
    } top_t;

    top_t r_d, r_q;
    logic det_s, prog, cs_rise, go, uv_sel_ok, active, run, irq_set, pres_now;
    cfg_t cfg;
    seq_e state;

    scm_detsync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(card_det), .q(det_s)
    );

    scm_cfgreg u_cfg (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .pgm_n(pgm_n),
        .addr({a1, a0}), .hio(hio_in), .hrst(hrst_in),
        .cfg(cfg), .prog(prog), .cs_rise(cs_rise)
    );

    scm_actseq #(.STEP_CYC(STEP_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .state(state)
    );

    assign uv_sel_ok = cfg.vsel ? uv5_ok : uv3_ok;
    assign go        = r_q.vcc_en & uv_sel_ok;
    assign active    = ~cs_n & ~pwr_on & ~a0 & ~a1 & pgm_n & ~prog;
    assign run       = (state == SEQ_CLK) || (state == SEQ_LIVE);

    always_comb begin
        r_d      = r_q;
        pres_now = det_s ^ cfg.pol;
        irq_set  = pres_now ^ r_q.pres;
        r_d.pres   = pres_now;
        r_d.irq    = irq_set | (r_q.irq & ~cs_rise);
        r_d.vcc_en = pwr_on & r_q.pres;
        r_d.status = active ? r_q.pres : uv_sel_ok;
        if (state == SEQ_LIVE && !prog) r_d.io_hold = hio_in;
        if (!prog) r_d.rst_hold = hrst_in;
        r_d.div = r_q.div + 1'b1;
        case (cfg.ckmode)
            2'd1:    r_d.cclk = r_q.div[0];
            2'd2:    r_d.cclk = r_q.div[1];
            2'd3:    r_d.cclk = r_q.div[2];
            default: r_d.cclk = 1'b0;
        endcase
        if (!run) r_d.cclk = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign card_vcc_en = r_q.vcc_en;
    assign card_vsel   = cfg.vsel;
    assign card_clk    = r_q.cclk;
    assign card_rst    = (state == SEQ_LIVE) & r_q.rst_hold;
    assign card_io     = r_q.io_hold;
    assign card_io_oe  = (state != SEQ_OFF);
    assign status      = r_q.status;
    assign irq         = r_q.irq;
    assign prog_mode   = prog;
    assign host_hiz    = prog | (state != SEQ_LIVE);

    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !irq_set) |=> !irq); // R6
    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> irq); // R6
    AST_RST_AFTER_IO: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |-> card_io_oe); // R9
    AST_OFF_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_OFF) |=> !card_clk); // R11
    AST_VCC_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> !card_vcc_en); // R7
endmodule

// File: tb/sc_mode_ctrl_test.sv
`timescale 1ns/1ps
module sc_mode_ctrl_test;
    localparam int STEP = 3;

    logic clk = 0, rst_n = 0;
    logic cs_n = 1, pwr_on = 0, pgm_n = 1, a0 = 0, a1 = 0;
    logic hio_in = 0, hrst_in = 0, card_det = 0, uv3_ok = 0, uv5_ok = 0;
    logic card_vcc_en, card_vsel, card_clk, card_rst, card_io, card_io_oe;
    logic status, irq, prog_mode, host_hiz;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    sc_mode_ctrl #(.STEP_CYC(STEP)) uut (.*);

    // {a1a0, io, rst, expected vsel, expected pol}
    localparam logic [5:0] VEC [6] = '{
        {2'b01, 1'b1, 1'b0, 1'b1, 1'b0},
        {2'b11, 1'b1, 1'b0, 1'b1, 1'b1},
        {2'b00, 1'b0, 1'b0, 1'b1, 1'b1},
        {2'b01, 1'b0, 1'b0, 1'b0, 1'b1},
        {2'b11, 1'b0, 1'b0, 1'b0, 1'b0},
        {2'b10, 1'b1, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic prog_write(input logic [1:0] ad, input logic io, input logic rs);
        @(negedge clk); cs_n = 1; pgm_n = 0; {a1, a0} = ad; hio_in = io; hrst_in = rs;
        @(negedge clk); cs_n = 0;
        @(negedge clk);
        @(negedge clk); cs_n = 1;
        @(negedge clk); pgm_n = 1; {a1, a0} = 2'b00;
    endtask

    task automatic count_clk(input int n, output int tr);
        logic prev;
        tr = 0;
        @(negedge clk); prev = card_clk;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (card_clk !== prev) tr++;
            prev = card_clk;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int fio, fclk, frst, tr;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 vcc_en", card_vcc_en, 0); chk("R1 vsel", card_vsel, 0);
        chk("R1 clk", card_clk, 0);       chk("R1 rst", card_rst, 0);
        chk("R1 io_oe", card_io_oe, 0);   chk("R1 irq", irq, 0);
        chk("R1 prog", prog_mode, 0);     chk("R1 hiz", host_hiz, 1);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // table walk: R3 writes, R5 status reports polarity in active mode
        for (int i = 0; i < 6; i++) begin
            prog_write(VEC[i][5:4], VEC[i][3], VEC[i][2]);
            chk("R3 vsel", card_vsel, VEC[i][1]);
            cs_n = 0; pgm_n = 1; {a1, a0} = 2'b00;
            repeat (3) @(negedge clk);
            chk("R5 status active", status, VEC[i][0]);
            cs_n = 1;
            @(negedge clk);
        end
        // R5 outside active mode: status = selected comparator (vsel=0 -> uv3)
        uv5_ok = 1; repeat (2) @(negedge clk);
        chk("R5 status uv3 sel", status, 0);
        uv3_ok = 1; uv5_ok = 0; repeat (2) @(negedge clk);
        chk("R5 status uv3 sel", status, 1);
        uv3_ok = 0;

        // R2 latch holds after strobe release; R4 no capture with strobe high
        @(negedge clk); pgm_n = 0; {a1, a0} = 2'b01; hio_in = 1;
        @(negedge clk); cs_n = 0;
        @(negedge clk); chk("R2 latched", prog_mode, 1);
        pgm_n = 1;
        @(negedge clk); chk("R2 held after release", prog_mode, 1);
        cs_n = 1;
        @(negedge clk); chk("R2 cleared", prog_mode, 0);
        chk("R4 vsel unchanged", card_vsel, 0);
        {a1, a0} = 2'b00;

        // clock mode 01, activation
        prog_write(2'b10, 1'b0, 1'b1);
        chk("R6 irq cleared", irq, 0);
        hio_in = 1; hrst_in = 1; card_det = 1; pwr_on = 1;
        repeat (6) @(negedge clk);
        chk("R6 irq on detect", irq, 1);
        chk("R7 vcc_en", card_vcc_en, 1);
        chk("R8 no start", card_io_oe, 0);
        uv5_ok = 1; repeat (10) @(negedge clk);
        chk("R8 wrong comparator", card_io_oe, 0);
        uv3_ok = 1;
        fio = -1; fclk = -1; frst = -1;
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            if (card_io_oe && fio < 0) fio = t;
            if (card_clk && fclk < 0) fclk = t;
            if (card_rst && frst < 0) frst = t;
        end
        chk("R9 io first", (fio >= 0) && (fclk > fio), 1);
        chk("R9 rst delay", frst - fio, 2 * STEP);
        chk("R9 clk before rst", (fclk >= 0) && (fclk <= frst), 1);
        // irq clear by cs pulse
        cs_n = 0; @(negedge clk); cs_n = 1; @(negedge clk);
        chk("R6 cs rise clears", irq, 0);

        // R10 divider modes
        count_clk(16, tr); chk("R10 mode01", tr, 16);
        prog_write(2'b10, 1'b1, 1'b0); @(negedge clk);
        count_clk(16, tr); chk("R10 mode10", tr, 8);
        prog_write(2'b10, 1'b1, 1'b1); @(negedge clk);
        count_clk(16, tr); chk("R10 mode11", tr, 4);
        prog_write(2'b10, 1'b0, 1'b0); @(negedge clk);
        count_clk(16, tr); chk("R10 mode00", tr, 0);
        chk("R10 mode00 low", card_clk, 0);

        // R12 pass-through
        hrst_in = 1; hio_in = 0; @(negedge clk);
        chk("R12 io follows", card_io, 0);
        chk("R12 hiz low", host_hiz, 0);
        hrst_in = 0; @(negedge clk);
        chk("R12 rst follows", card_rst, 0);
        hrst_in = 1; @(negedge clk);
        chk("R12 rst follows", card_rst, 1);
        pgm_n = 0; @(negedge clk); cs_n = 0; @(negedge clk);
        hio_in = 1; hrst_in = 0; @(negedge clk); @(negedge clk);
        chk("R12 io held", card_io, 0);
        chk("R12 rst held", card_rst, 1);
        chk("R12 hiz in prog", host_hiz, 1);
        cs_n = 1; @(negedge clk); pgm_n = 1; hrst_in = 1; @(negedge clk);

        // R11 supply loss
        prog_write(2'b10, 1'b0, 1'b1); @(negedge clk);
        uv3_ok = 0; @(negedge clk);
        chk("R11 io_oe drop", card_io_oe, 0);
        chk("R11 rst drop", card_rst, 0);
        @(negedge clk);
        chk("R11 clk low", card_clk, 0);
        count_clk(8, tr); chk("R11 clk stopped", tr, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule